// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Selector

This block decides which pending transmit mailbox a CAN controller sends next. Each cycle it sees a bitmap of pending transmit requests and a matching bitmap of mailboxes set up for transmission. It also sees the arbitration fields of every mailbox (11-bit base identifier, 18-bit extension, IDE and RTR flags) and a policy bit. A mailbox is eligible when it is both pending and set up for transmission. Mailbox 0 is always excluded, so the candidates are mailboxes 1 to 31.

The selection is made when the controller pulses `start` as it begins a new frame. The policy bit is sampled in that same cycle. With the policy bit set, the highest-numbered eligible mailbox wins. With it clear, the eligible mailbox whose arbitration key is numerically lowest wins, as it would on the wire. The result is registered and appears one cycle after `start`. It then stays fixed until the next `start`, so the frame in flight is never swapped part-way through.

Top module: `can_tx_mbox_sel`

## Requirements
- R1: While `rst` is high, and after it until the first `start`, `sel_valid` is 0 and `sel_index` is 0.
- R2: `sel_valid` and `sel_index` change only on the clock edge after a cycle with `start` high. Changes to any other input between starts, including `prio_by_mbox`, leave them unchanged.
- R3: With `prio_by_mbox` = 1 at `start`, the result is the highest-numbered eligible mailbox.
- R4: With `prio_by_mbox` = 0 at `start`, the result is the eligible mailbox with the lowest 32-bit unsigned key. The key is built as {base_id[10:0], ide ? 1 : rtr, ide, ide ? ext_id[17:0] : 18'b0, ide ? rtr : 0}.
- R5: In identifier mode, a standard data frame beats a standard remote frame with the same base identifier.
- R6: In identifier mode, a standard frame beats an extended frame with the same base identifier. Between two extended frames, the extension field and then RTR decide.
- R7: When two eligible keys are equal, the higher mailbox number wins.
- R8: A mailbox is eligible only when its bits in both `tx_pending` and `tx_enable` are 1. Mailbox 0 is never selected.
- R9: If no mailbox is eligible at `start`, `sel_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new selection |
| prio_by_mbox | input | 1 | 1: mailbox-number priority, 0: identifier priority |
| tx_pending | input | NUM_MB | Pending transmit requests, one bit per mailbox |
| tx_enable | input | NUM_MB | Mailbox set up for transmission |
| base_id | input | NUM_MB*11 | Base identifiers, mailbox i at [11*i +: 11] |
| ext_id | input | NUM_MB*18 | Extension identifiers, mailbox i at [18*i +: 18] |
| ide | input | NUM_MB | Extended-format flag per mailbox |
| rtr | input | NUM_MB | Remote-frame flag per mailbox |
| sel_valid | output | 1 | A winner was found at the last start |
| sel_index | output | $clog2(NUM_MB) | Winning mailbox number |

## Verification
Some properties hold on every cycle, and the assertions check those. They confirm that the outputs move only after a `start`, that a valid result names an eligible mailbox other than 0, that `sel_valid` matches whether any mailbox was eligible, and that in mailbox-number mode no eligible mailbox sits above the winner. The bench scenarios cover what an invariant cannot express, which is the ordering of arbitration keys. That includes data against remote frames, standard against extended frames with the same base identifier, ordering by extension field and RTR, and ties broken by mailbox number.

// File: rtl/can_txsel_pkg.sv
package can_txsel_pkg;
  localparam int BASE_W = 11;
  localparam int EXT_W  = 18;
  localparam int KEY_W  = BASE_W + 1 + 1 + EXT_W + 1;

  typedef logic [KEY_W-1:0] arb_key_t;

  // Key laid out in wire order so that a lower value wins on the bus.
  function automatic arb_key_t make_key(input logic [BASE_W-1:0] b,
                                        input logic [EXT_W-1:0]  e,
                                        input logic              x,
                                        input logic              r);
    if (x) return {b, 1'b1, 1'b1, e, r};
    else   return {b, r, 1'b0, {EXT_W{1'b0}}, 1'b0};
  endfunction
endpackage

// File: rtl/txsel_key_gen.sv
module txsel_key_gen
  import can_txsel_pkg::*;
#(
  parameter int NUM_MB = 32
) (
  input  logic [NUM_MB*BASE_W-1:0] base_id,
  input  logic [NUM_MB*EXT_W-1:0]  ext_id,
  input  logic [NUM_MB-1:0]        ide,
  input  logic [NUM_MB-1:0]        rtr,
  output arb_key_t                 keys [NUM_MB]
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_key
    assign keys[i] = make_key(base_id[i*BASE_W +: BASE_W],
                              ext_id[i*EXT_W +: EXT_W], ide[i], rtr[i]);
  end
endmodule

// File: rtl/txsel_id_arb.sv
module txsel_id_arb
  import can_txsel_pkg::*;
#(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic [NUM_MB-1:0] elig,
  input  arb_key_t          keys [NUM_MB],
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  arb_key_t best;

  // Ascending scan; "<=" lets a later (higher) mailbox take an equal key.
  always_comb begin
    found = 1'b0;
    best  = '1;
    idx   = '0;
    for (int i = 1; i < NUM_MB; i++) begin
      if (elig[i] && (!found || keys[i] <= best)) begin
        found = 1'b1;
        best  = keys[i];
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/txsel_num_arb.sv
module txsel_num_arb #(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic [NUM_MB-1:0] elig,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_MB - 1; i >= 1; i--) begin
      if (elig[i] && !found) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/can_tx_mbox_sel.sv
module can_tx_mbox_sel
  import can_txsel_pkg::*;
#(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     prio_by_mbox,
  input  logic [NUM_MB-1:0]        tx_pending,
  input  logic [NUM_MB-1:0]        tx_enable,
  input  logic [NUM_MB*BASE_W-1:0] base_id,
  input  logic [NUM_MB*EXT_W-1:0]  ext_id,
  input  logic [NUM_MB-1:0]        ide,
  input  logic [NUM_MB-1:0]        rtr,
  output logic                     sel_valid,
  output logic [IDX_W-1:0]         sel_index
);
  logic [NUM_MB-1:0] elig;
  arb_key_t          keys [NUM_MB];
  logic              id_found, num_found;
  logic [IDX_W-1:0]  id_idx, num_idx;

  assign elig = tx_pending & tx_enable & ~NUM_MB'(1);

  txsel_key_gen #(.NUM_MB(NUM_MB)) u_keys (
    .base_id(base_id), .ext_id(ext_id), .ide(ide), .rtr(rtr), .keys(keys));

  txsel_id_arb #(.NUM_MB(NUM_MB)) u_id_arb (
    .elig(elig), .keys(keys), .found(id_found), .idx(id_idx));

  txsel_num_arb #(.NUM_MB(NUM_MB)) u_num_arb (
    .elig(elig), .found(num_found), .idx(num_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_index <= '0;
    end else if (start) begin
      sel_valid <= prio_by_mbox ? num_found : id_found;
      sel_index <= prio_by_mbox ? num_idx   : id_idx;
    end
  end

  // Checker state: what the inputs looked like at the last edge.
  logic [NUM_MB-1:0] elig_d;
  logic              start_d, mode_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      elig_d  <= '0;
      start_d <= 1'b0;
      mode_d  <= 1'b0;
    end else begin
      elig_d  <= elig;
      start_d <= start;
      mode_d  <= prio_by_mbox;
    end
  end

  // R2
  hold_between_starts_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(sel_valid) && $stable(sel_index)));

  // R8
  winner_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    (start_d && sel_valid) |-> (sel_index != '0 && elig_d[sel_index]));

  // R9
  valid_matches_any_chk: assert property (@(posedge clk) disable iff (rst)
    start_d |-> (sel_valid == (elig_d != '0)));

  // R3
  none_above_winner_chk: assert property (@(posedge clk) disable iff (rst)
    (start_d && mode_d && sel_valid) |-> ((elig_d >> sel_index) == NUM_MB'(1)));
endmodule

// File: tb/can_tx_mbox_sel_bench.sv
module can_tx_mbox_sel_bench;
  localparam int N = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, start, mode;
  logic [N-1:0] pend, en, ide_v, rtr_v;
  logic [10:0] b_arr [N];
  logic [17:0] e_arr [N];
  logic [N*11-1:0] base_bus;
  logic [N*18-1:0] ext_bus;
  logic        sel_valid;
  logic [4:0]  sel_index;

  always_comb
    for (int i = 0; i < N; i++) begin
      base_bus[i*11 +: 11] = b_arr[i];
      ext_bus[i*18 +: 18]  = e_arr[i];
    end

  can_tx_mbox_sel u_can_tx_mbox_sel (
    .clk(clk), .rst(rst), .start(start), .prio_by_mbox(mode),
    .tx_pending(pend), .tx_enable(en), .base_id(base_bus), .ext_id(ext_bus),
    .ide(ide_v), .rtr(rtr_v), .sel_valid(sel_valid), .sel_index(sel_index));

  int checks = 0, errors = 0;

  task automatic check(input string req, input logic v, input logic [4:0] ix,
                       input logic ev, input logic [4:0] eix);
    checks++;
    if (v !== ev || (ev && ix !== eix)) begin
      errors++;
      $display("FAIL %s: valid=%0b index=%0d expected valid=%0b index=%0d",
               req, v, ix, ev, eix);
    end
  endtask

  task automatic do_sel;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic default_fields;
    for (int i = 0; i < N; i++) begin
      b_arr[i] = 11'h100 + 11'(i);
      e_arr[i] = '0;
    end
    ide_v = '0;
    rtr_v = '0;
  endtask

  // {mode, pending, enable, exp_valid, exp_index}
  localparam logic [70:0] VEC [8] = '{
    {1'b1, 32'h0000_00F0, 32'hFFFF_FFFF, 1'b1, 5'd7},
    {1'b0, 32'h0000_00F0, 32'hFFFF_FFFF, 1'b1, 5'd4},
    {1'b1, 32'h8000_0002, 32'hFFFF_FFFF, 1'b1, 5'd31},
    {1'b0, 32'h8000_0002, 32'hFFFF_FFFF, 1'b1, 5'd1},
    {1'b1, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 5'd0},
    {1'b0, 32'h00FF_0000, 32'h00F0_0000, 1'b1, 5'd20},
    {1'b1, 32'h00FF_0000, 32'h00F0_0000, 1'b1, 5'd23},
    {1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 5'd0}
  };

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: valid=x index=x expected valid=done index=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; mode = 1'b0; pend = '0; en = '1;
    default_fields();
    repeat (3) @(negedge clk);
    check("R1", sel_valid, sel_index, 1'b0, 5'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", sel_valid, sel_index, 1'b0, 5'd0);

    // Table walk: R3 mailbox order, R4 key order, R8 eligibility, R9 none
    for (int k = 0; k < 8; k++) begin
      mode = VEC[k][70];
      pend = VEC[k][69:38];
      en   = VEC[k][37:6];
      do_sel();
      check(k == 4 || k == 7 ? "R9" : (VEC[k][70] ? "R3" : "R4"),
            sel_valid, sel_index, VEC[k][5], VEC[k][4:0]);
    end

    // R2: no start, inputs change, output holds
    mode = 1'b1; pend = 32'h0000_0300; en = '1;
    do_sel();
    check("R2", sel_valid, sel_index, 1'b1, 5'd9);
    @(negedge clk) mode = 1'b0; pend = 32'h4000_0000;
    repeat (3) @(negedge clk);
    check("R2", sel_valid, sel_index, 1'b1, 5'd9);
    do_sel();
    check("R2", sel_valid, sel_index, 1'b1, 5'd30);

    // R5: std remote at 9 vs std data at 3, same base id
    mode = 1'b0; default_fields();
    b_arr[9] = 11'h055; rtr_v[9] = 1'b1;
    b_arr[3] = 11'h055;
    pend = 32'h0000_0208;
    do_sel();
    check("R5", sel_valid, sel_index, 1'b1, 5'd3);

    // R6: extended at 10 vs std remote at 2, same base
    default_fields();
    b_arr[10] = 11'h033; ide_v[10] = 1'b1; e_arr[10] = 18'd0;
    b_arr[2]  = 11'h033; rtr_v[2] = 1'b1;
    pend = 32'h0000_0404;
    do_sel();
    check("R6", sel_valid, sel_index, 1'b1, 5'd2);

    // R6: two extended frames, extension decides
    default_fields();
    b_arr[8]  = 11'h020; ide_v[8]  = 1'b1; e_arr[8]  = 18'd5;
    b_arr[14] = 11'h020; ide_v[14] = 1'b1; e_arr[14] = 18'd3;
    pend = 32'h0000_4100;
    do_sel();
    check("R6", sel_valid, sel_index, 1'b1, 5'd14);

    // R6: two extended frames, RTR decides
    default_fields();
    b_arr[15] = 11'h020; ide_v[15] = 1'b1; e_arr[15] = 18'd7; rtr_v[15] = 1'b1;
    b_arr[4]  = 11'h020; ide_v[4]  = 1'b1; e_arr[4]  = 18'd7;
    pend = 32'h0000_8010;
    do_sel();
    check("R6", sel_valid, sel_index, 1'b1, 5'd4);

    // R7: equal keys at 6 and 12
    default_fields();
    b_arr[6] = 11'h010; b_arr[12] = 11'h010;
    pend = 32'h0000_1040;
    do_sel();
    check("R7", sel_valid, sel_index, 1'b1, 5'd12);

    // R8: mailbox 0 has the lowest id but is never chosen
    default_fields();
    b_arr[0] = 11'h000;
    pend = 32'h0000_0021;
    do_sel();
    check("R8", sel_valid, sel_index, 1'b1, 5'd5);

    // R1: reset clears a valid result
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1", sel_valid, sel_index, 1'b0, 5'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule